// File: doc/BRIEF.md
# Per-Cycle Coprocessor Program Sequencer

This block is the fetch front end of a small measurement coprocessor whose program runs once per sampling-multiplexer cycle. A start strobe, raised when the multiplexer enters its first state, loads the program counter with zero. It also captures an 8-bit relocation value that selects the 1 KB-aligned flash window holding the program. The sequencer then requests 16-bit instruction words from a flash that it shares with a host processor. It waits whenever the sharing arbiter withholds the grant. Each fetched word goes to the execute stage with a one-cycle valid strobe.

A word of all zeros is the halt opcode. It ends the pass, and the sequencer stays idle until the next start strobe. Two conditions mean the program did not fit its time slot: the multiplexer cycle ends while a pass is still running, or the program counter runs past its last legal word. Either one stops the pass and sets a sticky overrun flag. Only reset clears that flag.

Top module: `cpx_pass_sequencer`

## Requirements
- R1: During and after reset, with no start strobe, busy, request, instruction valid, halt and overrun outputs are all 0.
- R2: A start strobe sampled at a clock edge makes busy and the flash request 1 from the next cycle, with program counter 0. The relocation value is captured at that edge, and later changes to the relocation input do not affect the running pass.
- R3: The flash address is the byte address relocation × 1024 + 2 × program counter, 19 bits wide with the default parameters.
- R4: While the request is 1 and the grant is 0, the request stays 1, the address is held and the program counter does not advance.
- R5: A grant accepts the request at a clock edge, and the flash returns the word in the following cycle. If that word is nonzero, instruction valid is 1 for exactly one cycle after the next edge, carrying the word and its program counter. The request for the next word follows in that same cycle.
- R6: A returned word equal to 16'h0000 is not issued. Halt pulses for one cycle instead, busy drops with it, and no further request is made until the next start strobe.
- R7: The cycle-end strobe while busy sets overrun and drops busy and request at the next edge. The cycle-end strobe while idle changes nothing.
- R8: If the word at program counter 4095 is nonzero, it is issued, and then the pass ends with overrun set instead of fetching a 4097th word.
- R9: A start strobe during a running pass restarts it at program counter 0 with the newly captured relocation, and does not set overrun.
- R10: Once set, overrun stays 1 through later passes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reloc_i | input | 8 | Program window selector in 1 KB units |
| mux_s0_i | input | 1 | Start-of-pass strobe (multiplexer state 0 begins) |
| cycle_end_i | input | 1 | Multiplexer cycle ends |
| fl_gnt_i | input | 1 | Flash access granted by the sharing arbiter |
| fl_req_o | output | 1 | Fetch request to flash |
| fl_addr_o | output | 19 | Flash byte address of the requested word |
| fl_rdata_i | input | 16 | Word returned by flash, one cycle after an accepted request |
| instr_valid_o | output | 1 | Instruction word valid for the execute stage |
| instr_o | output | 16 | Instruction word |
| instr_pc_o | output | 12 | Program counter of the issued word |
| halt_o | output | 1 | One-cycle pulse when the halt opcode ends a pass |
| busy_o | output | 1 | A pass is in progress |
| overrun_o | output | 1 | Sticky: pass outlived its cycle or ran off the program end |

## Verification
The assertions assume a flash that returns data exactly one cycle after each accepted request. They also assume that the start and cycle-end strobes are single-cycle pulses that the checker can sample directly. Beyond that, they assume nothing about how often those strobes arrive. In the bench, the flash model answers only on a cycle with both request and grant. Every input changes shortly after the falling edge, so it is stable at the next rising edge. The strobes are raised for exactly one cycle. The grant follows either a constant level or a pseudo-random pattern, so both uninterrupted and stalled fetch runs are covered.

// File: rtl/cpx_seq_pkg.sv
package cpx_seq_pkg;

   // sequencer phase
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

   // program-counter command
   typedef enum logic [1:0] {
      PC_HOLD  = 2'd0,
      PC_CLEAR = 2'd1,
      PC_STEP  = 2'd2
   } pc_op_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cpx_seq_pc.sv
module cpx_seq_pc
   import cpx_seq_pkg::*;
#(
   parameter int PC_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  pc_op_e          op_i,
   output logic [PC_W-1:0] pc_o,
   output logic            last_o
);

   localparam logic [PC_W-1:0] PC_TOP = {PC_W{1'b1}};

   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else begin
         unique case (op_i)
            PC_CLEAR: pc_q <= '0;
            PC_STEP:  pc_q <= pc_q + PC_W'(1);
            default:  pc_q <= pc_q;
         endcase
      end
   end

   assign pc_o   = pc_q;
   assign last_o = (pc_q == PC_TOP);

endmodule

// File: rtl/cpx_seq_addr.sv
module cpx_seq_addr #(
   parameter int RELOC_W    = 8,
   parameter int ALIGN_LOG2 = 10,
   parameter int PC_W       = 12,
   parameter bit WORD_ADDR  = 1'b0,
   parameter int ADDR_W     = 19
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [RELOC_W-1:0] reloc_i,
   input  logic [PC_W-1:0]    pc_i,
   output logic [ADDR_W-1:0]  addr_o
);

   logic [RELOC_W-1:0] reloc_q;
   logic [ADDR_W-1:0]  base_w;
   logic [ADDR_W-1:0]  offs_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reloc_q <= '0;
      end else if (load_i) begin
         reloc_q <= reloc_i;
      end
   end

   generate
      if (WORD_ADDR) begin : g_word
         // one address step per 16-bit word
         assign base_w = ADDR_W'(reloc_q) << (ALIGN_LOG2 - 1);
         assign offs_w = ADDR_W'(pc_i);
      end else begin : g_byte
         // one address step per byte, two bytes per word
         assign base_w = ADDR_W'(reloc_q) << ALIGN_LOG2;
         assign offs_w = ADDR_W'(pc_i) << 1;
      end
   endgenerate

   assign addr_o = base_w + offs_w;

endmodule

// File: rtl/cpx_seq_fsm.sv
module cpx_seq_fsm
   import cpx_seq_pkg::*;
#(
   parameter int          INSTR_W = 16,
   parameter int          PC_W    = 12,
   parameter logic [15:0] HALT_OP = 16'h0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               cyc_end_i,
   input  logic               gnt_i,
   input  logic [INSTR_W-1:0] rdata_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic               pc_last_i,
   output pc_op_e             pc_op_o,
   output logic               load_base_o,
   output logic               req_o,
   output logic               busy_o,
   output logic               instr_valid_o,
   output logic [INSTR_W-1:0] instr_o,
   output logic [PC_W-1:0]    instr_pc_o,
   output logic               halt_o,
   output logic               overrun_o
);

   localparam logic [INSTR_W-1:0] HALT_W = INSTR_W'(HALT_OP);

   seq_state_e state_q, state_d;
   pc_op_e     pc_op;
   logic       emit, saw_halt, ran_off, abort, ovr_set;
   logic       busy;

   assign busy  = (state_q != ST_IDLE);
   assign abort = cyc_end_i && busy;

   always_comb begin
      state_d  = state_q;
      pc_op    = PC_HOLD;
      emit     = 1'b0;
      saw_halt = 1'b0;
      ran_off  = 1'b0;
      unique case (state_q)
         ST_FETCH: begin
            if (gnt_i) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (rdata_i == HALT_W) begin
               saw_halt = 1'b1;
               state_d  = ST_IDLE;
            end else begin
               emit  = 1'b1;
               pc_op = PC_STEP;
               if (pc_last_i) begin
                  ran_off = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  state_d = ST_FETCH;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
      // a new pass or an expired cycle cancels the step in progress
      if (start_i) begin
         state_d  = ST_FETCH;
         pc_op    = PC_CLEAR;
         emit     = 1'b0;
         saw_halt = 1'b0;
         ran_off  = 1'b0;
      end else if (abort) begin
         state_d  = ST_IDLE;
         pc_op    = PC_HOLD;
         emit     = 1'b0;
         saw_halt = 1'b0;
         ran_off  = 1'b0;
      end
   end

   assign ovr_set = abort || ran_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         instr_valid_o <= 1'b0;
         instr_o       <= '0;
         instr_pc_o    <= '0;
         halt_o        <= 1'b0;
         overrun_o     <= 1'b0;
      end else begin
         state_q       <= state_d;
         instr_valid_o <= emit;
         halt_o        <= saw_halt;
         overrun_o     <= overrun_o || ovr_set;
         if (emit) begin
            instr_o    <= rdata_i;
            instr_pc_o <= pc_i;
         end
      end
   end

   assign pc_op_o     = pc_op;
   assign load_base_o = start_i;
   assign req_o       = (state_q == ST_FETCH);
   assign busy_o      = busy;

endmodule

// File: rtl/cpx_pass_sequencer.sv
module cpx_pass_sequencer
   import cpx_seq_pkg::*;
#(
   parameter int          RELOC_W    = 8,
   parameter int          ALIGN_LOG2 = 10,
   parameter int          PC_W       = 12,
   parameter int          INSTR_W    = 16,
   parameter bit          WORD_ADDR  = 1'b0,
   parameter logic [15:0] HALT_OP    = 16'h0000,
   parameter int          ADDR_W     = int'(max_u(RELOC_W + ALIGN_LOG2, PC_W + 1)) + 1
                                       - (WORD_ADDR ? 1 : 0)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RELOC_W-1:0] reloc_i,
   input  logic               mux_s0_i,
   input  logic               cycle_end_i,
   input  logic               fl_gnt_i,
   output logic               fl_req_o,
   output logic [ADDR_W-1:0]  fl_addr_o,
   input  logic [INSTR_W-1:0] fl_rdata_i,
   output logic               instr_valid_o,
   output logic [INSTR_W-1:0] instr_o,
   output logic [PC_W-1:0]    instr_pc_o,
   output logic               halt_o,
   output logic               busy_o,
   output logic               overrun_o
);

   localparam int NEED_W = int'(max_u(RELOC_W + ALIGN_LOG2, PC_W + 1)) + 1
                           - (WORD_ADDR ? 1 : 0);

   generate
      if (RELOC_W < 1 || PC_W < 1) begin : g_bad_width
         $error("cpx_pass_sequencer: RELOC_W and PC_W must be positive");
      end
      if (ALIGN_LOG2 < 1) begin : g_bad_align
         $error("cpx_pass_sequencer: ALIGN_LOG2 must be at least 1");
      end
      if (INSTR_W < 1 || INSTR_W > 16) begin : g_bad_instr
         $error("cpx_pass_sequencer: INSTR_W must be 1..16");
      end
      if (ADDR_W < NEED_W) begin : g_bad_addr
         $error("cpx_pass_sequencer: ADDR_W too narrow for window plus offset");
      end
   endgenerate

   pc_op_e          pc_op;
   logic [PC_W-1:0] pc;
   logic            pc_last;
   logic            load_base;

   cpx_seq_pc #(
      .PC_W (PC_W)
   ) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (pc_op),
      .pc_o   (pc),
      .last_o (pc_last)
   );

   cpx_seq_addr #(
      .RELOC_W    (RELOC_W),
      .ALIGN_LOG2 (ALIGN_LOG2),
      .PC_W       (PC_W),
      .WORD_ADDR  (WORD_ADDR),
      .ADDR_W     (ADDR_W)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_base),
      .reloc_i (reloc_i),
      .pc_i    (pc),
      .addr_o  (fl_addr_o)
   );

   cpx_seq_fsm #(
      .INSTR_W (INSTR_W),
      .PC_W    (PC_W),
      .HALT_OP (HALT_OP)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (mux_s0_i),
      .cyc_end_i     (cycle_end_i),
      .gnt_i         (fl_gnt_i),
      .rdata_i       (fl_rdata_i),
      .pc_i          (pc),
      .pc_last_i     (pc_last),
      .pc_op_o       (pc_op),
      .load_base_o   (load_base),
      .req_o         (fl_req_o),
      .busy_o        (busy_o),
      .instr_valid_o (instr_valid_o),
      .instr_o       (instr_o),
      .instr_pc_o    (instr_pc_o),
      .halt_o        (halt_o),
      .overrun_o     (overrun_o)
   );

endmodule

// File: rtl/cpx_pass_sequencer_chk.sv
module cpx_pass_sequencer_chk #(
   parameter int RELOC_W    = 8,
   parameter int ALIGN_LOG2 = 10,
   parameter int INSTR_W    = 16,
   parameter bit WORD_ADDR  = 1'b0,
   parameter int ADDR_W     = 19
) (
   input logic               clk,
   input logic               rst_n,
   input logic [RELOC_W-1:0] reloc_i,
   input logic               mux_s0_i,
   input logic               cycle_end_i,
   input logic               fl_gnt_i,
   input logic               fl_req_o,
   input logic [ADDR_W-1:0]  fl_addr_o,
   input logic               instr_valid_o,
   input logic [INSTR_W-1:0] instr_o,
   input logic               halt_o,
   input logic               busy_o,
   input logic               overrun_o
);

   localparam int BASE_SH = WORD_ADDR ? ALIGN_LOG2 - 1 : ALIGN_LOG2;

   // R1
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !fl_req_o);

   // R2
   start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mux_s0_i |=> busy_o && fl_req_o
                   && fl_addr_o == (ADDR_W'($past(reloc_i)) << BASE_SH));

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req_o && !fl_gnt_i && !mux_s0_i && !cycle_end_i
      |=> fl_req_o && $stable(fl_addr_o));

   // R5
   issue_nonhalt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid_o |-> instr_o != '0);

   // R6
   halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |-> !busy_o && !instr_valid_o);

   // R7
   late_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end_i && busy_o && !mux_s0_i |=> !busy_o && overrun_o);

   // R10
   sticky_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> overrun_o);

endmodule

bind cpx_pass_sequencer cpx_pass_sequencer_chk #(
   .RELOC_W    (RELOC_W),
   .ALIGN_LOG2 (ALIGN_LOG2),
   .INSTR_W    (INSTR_W),
   .WORD_ADDR  (WORD_ADDR),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reloc_i       (reloc_i),
   .mux_s0_i      (mux_s0_i),
   .cycle_end_i   (cycle_end_i),
   .fl_gnt_i      (fl_gnt_i),
   .fl_req_o      (fl_req_o),
   .fl_addr_o     (fl_addr_o),
   .instr_valid_o (instr_valid_o),
   .instr_o       (instr_o),
   .halt_o        (halt_o),
   .busy_o        (busy_o),
   .overrun_o     (overrun_o)
);

// File: tb/cpx_pass_sequencer_bench.sv
module cpx_pass_sequencer_bench;

   localparam int AW     = 19;
   localparam int PC_MAX = 4095;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reloc_i = '0;
   logic        mux_s0_i = 1'b0;
   logic        cycle_end_i = 1'b0;
   logic        fl_gnt_i = 1'b1;
   logic        fl_req_o;
   logic [AW-1:0] fl_addr_o;
   logic [15:0] fl_rdata_i = '0;
   logic        instr_valid_o;
   logic [15:0] instr_o;
   logic [11:0] instr_pc_o;
   logic        halt_o;
   logic        busy_o;
   logic        overrun_o;

   always #2 clk = ~clk;

   cpx_pass_sequencer u_cpx_pass_sequencer (
      .clk           (clk),
      .rst_n         (rst_n),
      .reloc_i       (reloc_i),
      .mux_s0_i      (mux_s0_i),
      .cycle_end_i   (cycle_end_i),
      .fl_gnt_i      (fl_gnt_i),
      .fl_req_o      (fl_req_o),
      .fl_addr_o     (fl_addr_o),
      .fl_rdata_i    (fl_rdata_i),
      .instr_valid_o (instr_valid_o),
      .instr_o       (instr_o),
      .instr_pc_o    (instr_pc_o),
      .halt_o        (halt_o),
      .busy_o        (busy_o),
      .overrun_o     (overrun_o)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    halt_wa = -1;
   bit    chk_on = 1'b0;
   bit    gnt_rand = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   string phase = "R1";

   // flash content: halt word at one chosen word address, else nonzero
   function automatic logic [15:0] wd(input int wa);
      logic [15:0] w;
      if (wa == halt_wa) return 16'h0000;
      w = {1'b1, wa[14:0]};
      return w;
   endfunction

   // flash responder: one-cycle read latency
   always @(posedge clk)
      if (fl_req_o && fl_gnt_i) fl_rdata_i <= wd(int'(fl_addr_o >> 1));

   // behavioural reference
   int          m_state = 0;
   int          m_pc = 0;
   int          m_base = 0;
   bit          m_ovr = 0;
   bit          m_valid = 0;
   bit          m_halt = 0;
   logic [15:0] m_instr = '0;
   int          m_ipc = 0;
   logic [15:0] m_q = '0;

   always @(posedge clk) begin
      bit was_busy;
      m_valid = 0;
      m_halt  = 0;
      if (!rst_n) begin
         m_state = 0; m_pc = 0; m_base = 0; m_ovr = 0;
      end else begin
         was_busy = (m_state != 0);
         if (cycle_end_i && was_busy) m_ovr = 1;
         if (mux_s0_i) begin
            m_state = 1; m_pc = 0; m_base = int'(reloc_i);
         end else if (cycle_end_i && was_busy) begin
            m_state = 0;
         end else if (m_state == 1) begin
            if (fl_gnt_i) begin
               m_q = wd(m_base * 512 + m_pc);
               m_state = 2;
            end
         end else if (m_state == 2) begin
            if (m_q == 16'h0000) begin
               m_halt = 1; m_state = 0;
            end else begin
               m_valid = 1; m_instr = m_q; m_ipc = m_pc;
               if (m_pc == PC_MAX) begin
                  m_ovr = 1; m_state = 0; m_pc = 0;
               end else begin
                  m_pc = m_pc + 1; m_state = 1;
               end
            end
         end
      end
   end

   task automatic cmp(input string f, input longint act, input longint exp, input string tag);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s (phase %s) %s: got %0h expected %0h", tag, phase, f, act, exp);
      end
   endtask

   always @(negedge clk) if (chk_on) begin
      cmp("busy", longint'(busy_o), longint'(m_state != 0), "R2");
      cmp("req", longint'(fl_req_o), longint'(m_state == 1), "R4");
      if (m_state == 1)
         cmp("addr", longint'(fl_addr_o), longint'(m_base * 1024 + 2 * m_pc), "R3");
      cmp("valid", longint'(instr_valid_o), longint'(m_valid), "R5");
      if (m_valid) begin
         cmp("instr", longint'(instr_o), longint'(m_instr), "R5");
         cmp("ipc", longint'(instr_pc_o), longint'(m_ipc), "R5");
      end
      cmp("halt", longint'(halt_o), longint'(m_halt), "R6");
      cmp("overrun", longint'(overrun_o), longint'(m_ovr), "R7");
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         fl_gnt_i = gnt_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
      end
   endtask

   task automatic start_pass(input logic [7:0] rl, input int halt_off);
      reloc_i  = rl;
      halt_wa  = (halt_off < 0) ? -1 : int'(rl) * 512 + halt_off;
      mux_s0_i = 1'b1;
      tick();
      mux_s0_i = 1'b0;
   endtask

   task automatic pulse_end();
      cycle_end_i = 1'b1;
      tick();
      cycle_end_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (phase %s): got running expected finished", phase);
      finish_run();
   end

   initial begin
      // R1: reset state
      @(posedge clk);
      chk_on = 1'b1;
      tick(3);
      rst_n = 1'b1;
      tick(4);

      // R2 R3 R5 R6: short program, relocation changed mid-pass
      phase = "R2";
      start_pass(8'd3, 5);
      tick(3);
      reloc_i = 8'd9;
      tick(20);

      // R4: stalls with pseudo-random grant at the top window
      phase = "R4";
      gnt_rand = 1'b1;
      start_pass(8'd255, 7);
      tick(60);
      gnt_rand = 1'b0;

      // R6: halt as the very first word
      phase = "R6";
      start_pass(8'd17, 0);
      tick(8);

      // R7: cycle end while idle has no effect
      phase = "R7";
      pulse_end();
      tick(3);

      // R9: restart during a pass
      phase = "R9";
      start_pass(8'd40, 60);
      tick(11);
      start_pass(8'd41, 4);
      tick(20);

      // R7: cycle end during a pass
      phase = "R7";
      start_pass(8'd5, 200);
      tick(12);
      pulse_end();
      tick(5);

      // R10: overrun stays set across a clean pass
      phase = "R10";
      start_pass(8'd6, 3);
      tick(15);
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      phase = "R1";
      tick(3);

      // R8: run past the last legal word
      phase = "R8";
      start_pass(8'd1, -1);
      tick(2 * (PC_MAX + 1) + 20);

      finish_run();
   end

endmodule